// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block controls one processor's small direct-mapped cache on a shared snooping bus and keeps that cache coherent under the write-once policy. Each cache line holds one data word. The controller serves the processor's reads and writes. It masters the bus for line fills, write-throughs and write-backs. It also watches the transactions that other masters place on the bus.

The first write to a clean line goes through to memory. Other caches see that write on the bus and drop their copies. Later writes to the same line stay in the cache. When another master reads a line that this cache holds dirty, the controller keeps memory from answering and drives the line itself. Memory takes the same data from the bus.

Per-line states: Invalid, Valid (clean, possibly shared), Reserved (written once, memory current), Dirty (written more than once, memory stale). The controller sequencer states are:

- IDLE: serves hits and accepts new requests.
- WBACK: writes a dirty victim back to memory.
- FILL: reads the requested line from memory.
- WTHRU: writes the first store through to memory.

The sequencer transitions are:

- IDLE to WBACK: a miss whose victim is Dirty.
- IDLE to FILL: a miss whose victim is clean or Invalid.
- IDLE to WTHRU: a write hit on a Valid line.
- WBACK to FILL: when the write-back completes.
- FILL to WTHRU: when the fill completes and the request is a write.
- FILL to IDLE: when the fill completes and the request is a read.
- WTHRU to IDLE: when the write-through completes.

Top module: `wo_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, the sequencer is IDLE, and `cpu_busy`, `cpu_done`, `bus_req` and `snp_inhibit` are low.
- R2: A read miss to a line with a clean or Invalid victim issues exactly one bus read (`bus_cmd` 0) for the request address. It fills the line as Valid and returns the word in the cycle `bus_done` is seen. The set index is the low address bits and the tag is the rest.
- R3: A read hit returns the cached word with `cpu_done` high in the request cycle and makes no bus transaction.
- R4: A write hit on a Valid line issues exactly one write-through (`bus_cmd` 1) that carries the data. The line then becomes Reserved.
- R5: A write hit on a Reserved or Dirty line updates the word locally, makes no bus transaction, and leaves the line Dirty.
- R6: A snooped read (`snp_cmd` 0) that hits a Dirty line raises `snp_inhibit` and drives the word on `snp_data` in the same cycle. The line then becomes Valid.
- R7: A snooped read that hits a Reserved line leaves `snp_inhibit` low and moves the line to Valid.
- R8: A snooped write-through (`snp_cmd` 1) or invalidate (`snp_cmd` 2) that hits a held line makes it Invalid. The next access to it is a miss.
- R9: Snooped traffic to a different tag or an Invalid set, and snooped write-backs (`snp_cmd` 3), leave the line state and data unchanged.
- R10: A miss whose victim is Dirty first writes the victim back (`bus_cmd` 3, victim address and data) and then issues the bus read.
- R11: A write miss fills the line with a bus read and then writes it through. The sequence ends with the line Reserved and holding the new word.
- R12: `cpu_busy` is high while a bus transaction is outstanding or a snoop is present. A request that arrives in the same cycle as a snoop is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | Transaction outstanding or snoop in progress |
| bus_req | output | 1 | Bus transaction active |
| bus_cmd | output | 2 | 0 read, 1 write-through, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data for write-through or write-back |
| bus_rdata | input | DW | Fill data, valid with `bus_done` |
| bus_done | input | 1 | Transaction completes this cycle |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | 0 read, 1 write-through, 2 invalidate, 3 write-back |
| snp_addr | input | AW | Snooped address |
| snp_inhibit | output | 1 | Memory must not answer; this cache supplies |
| snp_data | output | DW | Supplied word while inhibiting |

## Verification
Each line is walked through every state by a chain of reads, first writes, repeated writes and snoops. The number and kind of bus transactions per request separate the Valid, Reserved and Dirty states, which look the same to a plain read. A snooped read is tried against Dirty, Reserved, Invalid and mismatched-tag lines. A write that follows each snoop shows whether the line dropped to Valid, stayed put or went Invalid. Misses are tried with clean and dirty victims for both reads and writes, and a later refetch shows that write-back data reached memory.

// File: rtl/wo_pkg.sv
package wo_pkg;
    typedef enum logic [1:0] {
        L_INV   = 2'b00,
        L_VAL   = 2'b01,
        L_RES   = 2'b10,
        L_DIRTY = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WT  = 2'd1,
        CMD_INV = 2'd2,
        CMD_WB  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WBACK,
        S_FILL,
        S_WTHRU
    } ctl_st_t;
endpackage

// File: rtl/wo_line_array.sv
module wo_line_array
    import wo_pkg::*;
#(
    parameter int SETS = 4,
    parameter int TW   = 6,
    parameter int DW   = 16,
    localparam int IW  = $clog2(SETS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  rd_idx,
    output logic [TW-1:0]  rd_tag,
    output logic [DW-1:0]  rd_data,
    output line_st_t       rd_st,
    input  logic [IW-1:0]  sp_idx,
    output logic [TW-1:0]  sp_tag,
    output logic [DW-1:0]  sp_data,
    output line_st_t       sp_st,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [TW-1:0]  wr_tag,
    input  logic [DW-1:0]  wr_data,
    input  line_st_t       wr_st,
    input  logic           sw_en,
    input  line_st_t       sw_st
);
    logic [TW-1:0] tag_q [SETS];
    logic [DW-1:0] dat_q [SETS];
    line_st_t      st_q  [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        logic [TW-1:0] tag_r;
        logic [DW-1:0] dat_r;
        line_st_t      st_r;
        logic          cpu_sel;
        logic          snp_sel;

        assign cpu_sel = wr_en && (wr_idx == IW'(g));
        assign snp_sel = sw_en && (sp_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_r <= '0;
                dat_r <= '0;
                st_r  <= L_INV;
            end else begin
                if (cpu_sel) begin
                    tag_r <= wr_tag;
                    dat_r <= wr_data;
                end
                if (snp_sel) begin
                    st_r <= sw_st;
                end else if (cpu_sel) begin
                    st_r <= wr_st;
                end
            end
        end

        assign tag_q[g] = tag_r;
        assign dat_q[g] = dat_r;
        assign st_q[g]  = st_r;
    end

    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = dat_q[rd_idx];
    assign rd_st   = st_q[rd_idx];
    assign sp_tag  = tag_q[sp_idx];
    assign sp_data = dat_q[sp_idx];
    assign sp_st   = st_q[sp_idx];
endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
    import wo_pkg::*;
#(
    parameter int TW = 6,
    parameter int DW = 16
) (
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [TW-1:0] snp_tag,
    input  logic [TW-1:0] line_tag,
    input  line_st_t      line_st,
    input  logic [DW-1:0] line_data,
    output logic          inhibit,
    output logic [DW-1:0] supply_data,
    output logic          sw_en,
    output line_st_t      sw_st
);
    logic held;

    assign held = snp_valid && (line_st != L_INV) && (line_tag == snp_tag);

    always_comb begin
        inhibit = 1'b0;
        sw_en   = 1'b0;
        sw_st   = line_st;
        unique case (bus_cmd_t'(snp_cmd))
            CMD_RD: begin
                if (held && (line_st == L_DIRTY)) begin
                    inhibit = 1'b1;
                    sw_en   = 1'b1;
                    sw_st   = L_VAL;
                end else if (held && (line_st == L_RES)) begin
                    sw_en = 1'b1;
                    sw_st = L_VAL;
                end
            end
            CMD_WT, CMD_INV: begin
                if (held) begin
                    sw_en = 1'b1;
                    sw_st = L_INV;
                end
            end
            CMD_WB: begin
                sw_en = 1'b0;
            end
            default: sw_en = 1'b0;
        endcase
    end

    assign supply_data = inhibit ? line_data : '0;
endmodule

// File: rtl/wo_cache_ctrl.sv
module wo_cache_ctrl
    import wo_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int SETS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_done,
    output logic          cpu_busy,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_done,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_inhibit,
    output logic [DW-1:0] snp_data
);
    localparam int IW = $clog2(SETS);
    localparam int TW = AW - IW;

    ctl_st_t       state, nxt;
    logic          req_we;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;

    logic [IW-1:0] lk_idx;
    logic [TW-1:0] lk_tag, ln_tag, sp_tag;
    logic [DW-1:0] ln_data, sp_data;
    line_st_t      ln_st, sp_st;
    logic          hit, accept;

    logic          wr_en;
    logic [TW-1:0] wr_tag;
    logic [DW-1:0] wr_data;
    line_st_t      wr_st;
    logic          sw_en;
    line_st_t      sw_st;

    assign lk_idx = (state == S_IDLE) ? cpu_addr[IW-1:0]  : req_addr[IW-1:0];
    assign lk_tag = (state == S_IDLE) ? cpu_addr[AW-1:IW] : req_addr[AW-1:IW];
    assign hit    = (ln_st != L_INV) && (ln_tag == lk_tag);
    assign accept = (state == S_IDLE) && cpu_req && !snp_valid;

    wo_line_array #(.SETS(SETS), .TW(TW), .DW(DW)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_tag  (ln_tag),
        .rd_data (ln_data),
        .rd_st   (ln_st),
        .sp_idx  (snp_addr[IW-1:0]),
        .sp_tag  (sp_tag),
        .sp_data (sp_data),
        .sp_st   (sp_st),
        .wr_en   (wr_en),
        .wr_idx  (lk_idx),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .wr_st   (wr_st),
        .sw_en   (sw_en),
        .sw_st   (sw_st)
    );

    wo_snoop_unit #(.TW(TW), .DW(DW)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .snp_tag     (snp_addr[AW-1:IW]),
        .line_tag    (sp_tag),
        .line_st     (sp_st),
        .line_data   (sp_data),
        .inhibit     (snp_inhibit),
        .supply_data (snp_data),
        .sw_en       (sw_en),
        .sw_st       (sw_st)
    );

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                req_we    <= cpu_we;
                req_addr  <= cpu_addr;
                req_wdata <= cpu_wdata;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        if (cpu_we && (ln_st == L_VAL)) nxt = S_WTHRU;
                    end else if (ln_st == L_DIRTY) begin
                        nxt = S_WBACK;
                    end else begin
                        nxt = S_FILL;
                    end
                end
            end
            S_WBACK: if (bus_done) nxt = S_FILL;
            S_FILL:  if (bus_done) nxt = req_we ? S_WTHRU : S_IDLE;
            S_WTHRU: if (bus_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_done  = 1'b0;
        cpu_rdata = ln_data;
        bus_req   = 1'b0;
        bus_cmd   = CMD_RD;
        bus_addr  = req_addr;
        bus_wdata = req_wdata;
        wr_en     = 1'b0;
        wr_tag    = lk_tag;
        wr_data   = cpu_wdata;
        wr_st     = L_DIRTY;
        unique case (state)
            S_IDLE: begin
                if (accept && hit) begin
                    if (!cpu_we) begin
                        cpu_done = 1'b1;
                    end else if (ln_st != L_VAL) begin
                        cpu_done = 1'b1;
                        wr_en    = 1'b1;
                    end
                end
            end
            S_WBACK: begin
                bus_req   = 1'b1;
                bus_cmd   = CMD_WB;
                bus_addr  = {ln_tag, req_addr[IW-1:0]};
                bus_wdata = ln_data;
            end
            S_FILL: begin
                bus_req = 1'b1;
                if (bus_done) begin
                    wr_en     = 1'b1;
                    wr_data   = bus_rdata;
                    wr_st     = L_VAL;
                    cpu_rdata = bus_rdata;
                    cpu_done  = !req_we;
                end
            end
            S_WTHRU: begin
                bus_req = 1'b1;
                bus_cmd = CMD_WT;
                if (bus_done) begin
                    wr_en    = 1'b1;
                    wr_data  = req_wdata;
                    wr_st    = L_RES;
                    cpu_done = 1'b1;
                end
            end
            default: bus_req = 1'b0;
        endcase
    end

    assign cpu_busy = (state != S_IDLE) || snp_valid;

    p_bus_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_busy);
    p_snoop_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && snp_valid) |=> (state == S_IDLE));
    p_inhibit_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_inhibit |-> (snp_valid && snp_cmd == CMD_RD));
    p_wb_then_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WBACK && bus_done) |=> (bus_req && bus_cmd == CMD_RD));
    p_wt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WTHRU && bus_done) |=> !bus_req);
    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cpu_done) |-> !bus_req);
endmodule

// File: tb/wo_cache_ctrl_tb.sv
`timescale 1ns/100ps
module wo_cache_ctrl_tb;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SN = 2'd2;
    localparam logic [1:0] C_RD = 2'd0, C_WT = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  scmd;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp;
        logic [1:0]  ntx;
        logic [1:0]  lcmd;
        logic        inh;
        logic [3:0]  req;
    } vec_t;

    // op, snoop cmd, addr, wdata, expected data, bus txns, last cmd, inhibit, requirement
    localparam vec_t VECS [27] = '{
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'hA504, 2'd1, C_RD, 1'b0, 4'd2},  // R2 miss fill
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'hA504, 2'd0, C_RD, 1'b0, 4'd3},  // R3 hit
        '{OP_WR, C_RD,  8'h04, 16'h1111, 16'h0000, 2'd1, C_WT, 1'b0, 4'd4},  // R4 first write
        '{OP_WR, C_RD,  8'h04, 16'h2222, 16'h0000, 2'd0, C_RD, 1'b0, 4'd5},  // R5 local
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'h2222, 2'd0, C_RD, 1'b0, 4'd5},
        '{OP_SN, C_RD,  8'h04, 16'h0000, 16'h2222, 2'd0, C_RD, 1'b1, 4'd6},  // R6 supply
        '{OP_WR, C_RD,  8'h04, 16'h3333, 16'h0000, 2'd1, C_WT, 1'b0, 4'd6},  // now Valid
        '{OP_SN, C_RD,  8'h04, 16'h0000, 16'h0000, 2'd0, C_RD, 1'b0, 4'd7},  // R7 Reserved
        '{OP_WR, C_RD,  8'h04, 16'h4444, 16'h0000, 2'd1, C_WT, 1'b0, 4'd7},
        '{OP_WR, C_RD,  8'h04, 16'h5555, 16'h0000, 2'd0, C_RD, 1'b0, 4'd5},
        '{OP_RD, C_RD,  8'h08, 16'h0000, 16'hA508, 2'd2, C_RD, 1'b0, 4'd10}, // R10 wb+rd
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'h5555, 2'd1, C_RD, 1'b0, 4'd10},
        '{OP_SN, C_WT,  8'h04, 16'h0000, 16'h0000, 2'd0, C_RD, 1'b0, 4'd8},  // R8
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'h5555, 2'd1, C_RD, 1'b0, 4'd8},
        '{OP_SN, C_INV, 8'h04, 16'h0000, 16'h0000, 2'd0, C_RD, 1'b0, 4'd8},
        '{OP_WR, C_RD,  8'h04, 16'h6666, 16'h0000, 2'd2, C_WT, 1'b0, 4'd11}, // R11
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'h6666, 2'd0, C_RD, 1'b0, 4'd11},
        '{OP_SN, C_RD,  8'h05, 16'h0000, 16'h0000, 2'd0, C_RD, 1'b0, 4'd9},  // R9
        '{OP_SN, C_RD,  8'h44, 16'h0000, 16'h0000, 2'd0, C_RD, 1'b0, 4'd9},
        '{OP_WR, C_RD,  8'h04, 16'h7777, 16'h0000, 2'd0, C_RD, 1'b0, 4'd9},
        '{OP_SN, C_WB,  8'h04, 16'h0000, 16'h0000, 2'd0, C_RD, 1'b0, 4'd9},
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'h7777, 2'd0, C_RD, 1'b0, 4'd9},
        '{OP_SN, C_RD,  8'h04, 16'h0000, 16'h7777, 2'd0, C_RD, 1'b1, 4'd6},
        '{OP_WR, C_RD,  8'h04, 16'h9999, 16'h0000, 2'd1, C_WT, 1'b0, 4'd4},
        '{OP_WR, C_RD,  8'h04, 16'hAAAA, 16'h0000, 2'd0, C_RD, 1'b0, 4'd5},
        '{OP_WR, C_RD,  8'h0C, 16'hBBBB, 16'h0000, 2'd3, C_WT, 1'b0, 4'd11},
        '{OP_RD, C_RD,  8'h04, 16'h0000, 16'hAAAA, 2'd1, C_RD, 1'b0, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_done, cpu_busy;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_done;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_inhibit;
    logic [15:0] snp_data;

    int checks = 0, errors = 0;
    int txn_cnt;
    logic [1:0] last_cmd;
    logic [15:0] mem [256];
    logic mem_cnt;

    always #2.5 clk = ~clk;

    wo_cache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_done(bus_done),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_inhibit(snp_inhibit), .snp_data(snp_data)
    );

    // fixed-latency memory model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'hA500 | 16'(i);
            bus_done  <= 1'b0;
            bus_rdata <= '0;
            mem_cnt   <= 1'b0;
            txn_cnt   <= 0;
            last_cmd  <= C_RD;
        end else begin
            bus_done <= 1'b0;
            if (bus_req && !bus_done) begin
                if (mem_cnt) begin
                    mem_cnt   <= 1'b0;
                    bus_done  <= 1'b1;
                    bus_rdata <= mem[bus_addr];
                    txn_cnt   <= txn_cnt + 1;
                    last_cmd  <= bus_cmd;
                    if (bus_cmd == C_WT || bus_cmd == C_WB) mem[bus_addr] <= bus_wdata;
                end else begin
                    mem_cnt <= 1'b1;
                end
            end
            if (snp_valid && snp_cmd == C_RD && snp_inhibit) mem[snp_addr] <= snp_data;
        end
    end

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                          input int req, output logic [15:0] rd);
        int w;
        bit busy_seen;
        w = 0;
        busy_seen = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_done && w < 200) begin
            if (bus_req && !busy_seen) begin
                busy_seen = 1'b1;
                check(cpu_busy == 1'b1, 12, 32'(cpu_busy), 1, "busy while bus active (R12)");
            end
            @(negedge clk);
            #1;
            w++;
        end
        if (w >= 200) check(1'b0, req, 0, 1, "request never completed");
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        logic [15:0] rd;
        int t0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(cpu_busy == 1'b0, 1, 32'(cpu_busy), 0, "busy after reset (R1)");
        check(bus_req == 1'b0, 1, 32'(bus_req), 0, "bus_req after reset (R1)");
        check(cpu_done == 1'b0 && snp_inhibit == 1'b0, 1,
              32'({cpu_done, snp_inhibit}), 0, "done/inhibit after reset (R1)");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: line at index 2 is Invalid, so a read misses
        t0 = txn_cnt;
        cpu_op(1'b0, 8'h02, 16'h0, 1, rd);
        check(txn_cnt - t0 == 1, 1, 32'(txn_cnt - t0), 1, "initial line not Invalid (R1)");
        check(rd == 16'hA502, 2, 32'(rd), 32'h A502, "fill data (R2)");

        foreach (VECS[k]) begin
            vec_t v;
            v = VECS[k];
            t0 = txn_cnt;
            if (v.op == OP_SN) begin
                @(negedge clk);
                snp_valid = 1'b1; snp_cmd = v.scmd; snp_addr = v.addr;
                #1;
                check(snp_inhibit == v.inh, int'(v.req), 32'(snp_inhibit), 32'(v.inh),
                      $sformatf("vec %0d inhibit", k));
                if (v.inh)
                    check(snp_data == v.exp, int'(v.req), 32'(snp_data), 32'(v.exp),
                          $sformatf("vec %0d supplied data", k));
                @(negedge clk);
                snp_valid = 1'b0;
            end else begin
                cpu_op(v.op == OP_WR, v.addr, v.wdata, int'(v.req), rd);
                if (v.op == OP_RD)
                    check(rd == v.exp, int'(v.req), 32'(rd), 32'(v.exp),
                          $sformatf("vec %0d read data", k));
                check(txn_cnt - t0 == int'(v.ntx), int'(v.req), 32'(txn_cnt - t0),
                      32'(v.ntx), $sformatf("vec %0d bus transactions", k));
                if (v.ntx != 0)
                    check(last_cmd == v.lcmd, int'(v.req), 32'(last_cmd), 32'(v.lcmd),
                          $sformatf("vec %0d last bus command", k));
            end
        end

        // R12: snoop and request in the same cycle; request must wait
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = 8'h07;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h04;
        #1;
        check(cpu_done == 1'b0, 12, 32'(cpu_done), 0, "request taken during snoop (R12)");
        check(cpu_busy == 1'b1, 12, 32'(cpu_busy), 1, "busy during snoop (R12)");
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check(cpu_done == 1'b1 && cpu_rdata == 16'hAAAA, 12, 32'({cpu_done, cpu_rdata}),
              32'h1AAAA, "request after snoop (R12)");
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        check(cpu_busy == 1'b0, 12, 32'(cpu_busy), 0, "busy after completion (R12)");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule